// File: doc/BRIEF.md
# Four-Channel DMA Host Register File

This block is the register file that a host processor programs to set up a four-channel DMA controller over an 8-bit I/O bus with a 4-bit port offset. Each channel has a 16-bit start address and a 16-bit transfer count. Both are written and read one byte at a time through one port per register. A pointer flip-flop, shared by all channels, selects which byte each access reaches. The block also holds the control ports: command/status, software request, single-channel mask, mode, pointer clear, master clear, clear-all-masks and load-all-masks.

A transfer engine sits beside the block. It reads each channel's base values, current values, mode and mask from the outputs. It reports terminal-count events and hardware requests. It writes advanced current address and count values back through an update port. Reads return data combinationally while `io_rd` is high. Every state change takes effect on the rising clock edge that ends the access.

Top module: `chdma_regfile`

## Requirements
- R1: A write to offset 2n (address) or 2n+1 (count) of channel n loads the data byte into both the base and the current copy of that register. The low byte is loaded when the pointer is 0 and the high byte when it is 1.
- R2: Every read or write to offsets 0x0 to 0x7 toggles the pointer. A read returns the byte of the current copy that the pointer selects.
- R3: Any write to offset 0xC returns the pointer to 0 (low byte). Reset does the same.
- R4: A write to offset 0xA selects a channel with data bits [1:0]. Data bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. The other channels' mask bits are unchanged.
- R5: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads the mask bits from data bits [3:0] and ignores bits [7:4].
- R6: A write to offset 0xB selects a channel with data bits [1:0] and stores data bits [7:2] as that channel's 6-bit mode. The auto-initialize output of that channel equals data bit 4.
- R7: A write to offset 0x8 stores the command byte on `cmd_o`. A read of offset 0x8 returns status: terminal-count flags in bits [3:0], and in bits [7:4] the OR of the software and hardware requests.
- R8: A status read clears the terminal-count flags at the end of the read cycle. A terminal-count event that arrives in the same cycle is kept.
- R9: A write to offset 0x9 selects a channel with data bits [1:0]. Data bit 2 sets (1) or clears (0) that channel's software request.
- R10: A write to offset 0xD (master clear) does the following: resets the pointer, the command byte, the terminal-count flags and the software requests; sets all four mask bits; keeps the address, count and mode registers. Reads of offsets 0x9 to 0xF return 0x00.
- R11: After reset the mask bits are all 1 and all other registers are 0.
- R12: With `upd_en_i` high, the current address and count of channel `upd_ch_i` take the update values and the base copies stay unchanged. A host byte write in the same cycle overrides its byte of the current copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Port offset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| tc_set_i | input | 4 | Terminal-count event per channel |
| dreq_i | input | 4 | Hardware request per channel |
| upd_en_i | input | 1 | Engine write-back strobe |
| upd_ch_i | input | 2 | Engine write-back channel |
| upd_addr_i | input | 16 | New current address |
| upd_cnt_i | input | 16 | New current count |
| mask_o | output | 4 | Channel mask bits, 1 = disabled |
| mode_o | output | 24 | Six mode bits per channel, channel c at [6c+5:6c] |
| autoinit_o | output | 4 | Auto-initialize enable per channel |
| sw_req_o | output | 4 | Software request per channel |
| cmd_o | output | 8 | Command byte |
| base_addr_o | output | 64 | Base address, channel c at [16c+15:16c] |
| base_cnt_o | output | 64 | Base count, channel c at [16c+15:16c] |
| cur_addr_o | output | 64 | Current address, channel c at [16c+15:16c] |
| cur_cnt_o | output | 64 | Current count, channel c at [16c+15:16c] |

## Verification
Read data is combinational. The bench therefore checks `io_rdata` 1 ns after it drives a read, before the clock edge that carries out the read's side effects: the pointer toggle and the terminal-count clear. Register outputs change on the single edge inside a write or update access. They are checked at the following falling edge, one cycle after the strobe. A pointer toggle or a status clear is only seen by the next read, so each of these is checked as a pair of back-to-back reads. The reads that expect the other byte, or the cleared flags, fall one access later.

// File: rtl/chdma_pkg.sv
// Package: shared sizes and port offsets of the DMA host register file.
// Assumes a 4-bit port offset and four channels addressed by two bits.
package chdma_pkg;
    localparam int NCH   = 4;
    localparam int CHW   = 2;
    localparam int DW    = 8;
    localparam int RW    = 2 * DW;
    localparam int MODEW = DW - CHW;

    typedef logic [3:0] port_t;

    localparam port_t P_CMDSTAT = 4'h8;
    localparam port_t P_REQ     = 4'h9;
    localparam port_t P_SMASK   = 4'hA;
    localparam port_t P_MODE    = 4'hB;
    localparam port_t P_PTRCLR  = 4'hC;
    localparam port_t P_MCLR    = 4'hD;
    localparam port_t P_MASKCLR = 4'hE;
    localparam port_t P_MASKALL = 4'hF;
endpackage

// File: rtl/chdma_ptr.sv
// Module: shared low/high byte pointer for all 16-bit channel registers.
// Assumes clr and step come from decoded single-cycle host accesses.
module chdma_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic hi
);
    // Clear has priority over the toggle that each word-port access causes
    always_ff @(posedge clk) begin
        if (!rst_n)    hi <= 1'b0;
        else if (clr)  hi <= 1'b0;
        else if (step) hi <= ~hi;
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi); // R3
    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (hi != $past(hi))); // R2
endmodule

// File: rtl/chdma_chan.sv
// Module: one channel's base and current address and count registers.
// Assumes at most one host byte write per cycle; host bytes override
// the engine update of the current copy in the same cycle.
module chdma_chan #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_addr,
    input  logic            wr_cnt,
    input  logic            hi,
    input  logic [DW-1:0]   wdata,
    input  logic            upd,
    input  logic [2*DW-1:0] upd_addr,
    input  logic [2*DW-1:0] upd_cnt,
    output logic [2*DW-1:0] base_addr,
    output logic [2*DW-1:0] base_cnt,
    output logic [2*DW-1:0] cur_addr,
    output logic [2*DW-1:0] cur_cnt
);
    localparam int RW = 2 * DW;

    logic [1:0]    wr_w;
    logic [RW-1:0] upd_w [2];

    assign wr_w     = {wr_cnt, wr_addr};
    assign upd_w[0] = upd_addr;
    assign upd_w[1] = upd_cnt;

    for (genvar w = 0; w < 2; w++) begin : g_word
        logic [RW-1:0] base_q;
        logic [RW-1:0] cur_q;

        // Holds one 16-bit register pair: host bytes load both copies
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                cur_q  <= '0;
            end else begin
                if (upd) cur_q <= upd_w[w];
                if (wr_w[w]) begin
                    if (hi) begin
                        base_q[RW-1:DW] <= wdata;
                        cur_q[RW-1:DW]  <= wdata;
                    end else begin
                        base_q[DW-1:0]  <= wdata;
                        cur_q[DW-1:0]   <= wdata;
                    end
                end
            end
        end
    end

    assign base_addr = g_word[0].base_q;
    assign cur_addr  = g_word[0].cur_q;
    assign base_cnt  = g_word[1].base_q;
    assign cur_cnt   = g_word[1].cur_q;

    AST_WR_LOW_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr && !hi) |=> (base_addr[DW-1:0] == $past(wdata))
                              && (cur_addr[DW-1:0] == $past(wdata))); // R1
    AST_UPD_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_addr && !wr_cnt) |=> ($stable(base_addr) && $stable(base_cnt))); // R12
endmodule

// File: rtl/chdma_ctrl.sv
// Module: control ports - command, status, request, mask and mode.
// Assumes wr and rd are never high together; port is the 4-bit offset.
module chdma_ctrl
    import chdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  port_t             port,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH-1:0]    tc_set,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    mask,
    output logic [NCH*MODEW-1:0] mode,
    output logic [NCH-1:0]    swreq,
    output logic [DW-1:0]     cmd,
    output logic [DW-1:0]     status,
    output logic              ptr_clr
);
    logic wr_cmd, wr_req, wr_smask, wr_mode, wr_mclr, wr_maskclr, wr_maskall, rd_stat;
    logic [CHW-1:0] sel_ch;
    logic [NCH-1:0] tc_q;

    // Decodes the control-port strobes
    always_comb begin
        wr_cmd     = wr && (port == P_CMDSTAT);
        wr_req     = wr && (port == P_REQ);
        wr_smask   = wr && (port == P_SMASK);
        wr_mode    = wr && (port == P_MODE);
        wr_mclr    = wr && (port == P_MCLR);
        wr_maskclr = wr && (port == P_MASKCLR);
        wr_maskall = wr && (port == P_MASKALL);
        rd_stat    = rd && (port == P_CMDSTAT);
        sel_ch     = wdata[CHW-1:0];
    end

    assign ptr_clr = wr_mclr || (wr && (port == P_PTRCLR));

    // Mask bits: master clear sets all, clear-all, load-all or single channel
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) mask <= '1;
        else if (wr_maskclr)   mask <= '0;
        else if (wr_maskall)   mask <= wdata[NCH-1:0];
        else if (wr_smask)     mask[sel_ch] <= wdata[2];
    end

    // Command byte and software requests, both cleared by master clear
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) begin
            cmd   <= '0;
            swreq <= '0;
        end else begin
            if (wr_cmd) cmd <= wdata;
            if (wr_req) swreq[sel_ch] <= wdata[2];
        end
    end

    // Terminal-count flags: a status read clears them, new events still land
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) tc_q <= '0;
        else                   tc_q <= (rd_stat ? '0 : tc_q) | tc_set;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_mode
        // Stores the mode bits above the channel select for channel c
        always_ff @(posedge clk) begin
            if (!rst_n) mode[c*MODEW +: MODEW] <= '0;
            else if (wr_mode && (sel_ch == CHW'(c)))
                mode[c*MODEW +: MODEW] <= wdata[DW-1:CHW];
        end
    end

    assign status = {swreq | dreq, tc_q};

    AST_MCLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> (mask == '1) && (cmd == '0) && (swreq == '0)); // R10
    AST_STAT_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && (tc_set == '0)) |=> (tc_q == '0)); // R8
    AST_TC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((tc_set != '0) && !wr_mclr) |=> ((tc_q & $past(tc_set)) == $past(tc_set))); // R8
    AST_MASKALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_maskall |=> (mask == $past(wdata[NCH-1:0]))); // R5
endmodule

// File: rtl/chdma_regfile.sv
// Module: top of the DMA host register file. Decodes the 4-bit offset,
// routes word-port bytes to the channels and muxes read data.
// Assumes single-cycle strobes with io_wr and io_rd never both high.
module chdma_regfile
    import chdma_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   io_addr,
    input  logic         io_wr,
    input  logic         io_rd,
    input  logic [7:0]   io_wdata,
    output logic [7:0]   io_rdata,
    input  logic [3:0]   tc_set_i,
    input  logic [3:0]   dreq_i,
    input  logic         upd_en_i,
    input  logic [1:0]   upd_ch_i,
    input  logic [15:0]  upd_addr_i,
    input  logic [15:0]  upd_cnt_i,
    output logic [3:0]   mask_o,
    output logic [23:0]  mode_o,
    output logic [3:0]   autoinit_o,
    output logic [3:0]   sw_req_o,
    output logic [7:0]   cmd_o,
    output logic [63:0]  base_addr_o,
    output logic [63:0]  base_cnt_o,
    output logic [63:0]  cur_addr_o,
    output logic [63:0]  cur_cnt_o
);
    localparam int AUTO_BIT = 4 - CHW;

    logic           word_sel, is_cnt, hi, ptr_clr;
    logic [CHW-1:0] wch;
    logic [DW-1:0]  status;
    logic [RW-1:0]  cur_a [NCH];
    logic [RW-1:0]  cur_c [NCH];
    logic [RW-1:0]  rd_word;

    assign word_sel = ~io_addr[3];
    assign wch      = io_addr[2:1];
    assign is_cnt   = io_addr[0];

    chdma_ptr u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ptr_clr),
        .step (word_sel && (io_wr || io_rd)),
        .hi   (hi)
    );

    chdma_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (io_wr),
        .rd     (io_rd),
        .port   (io_addr),
        .wdata  (io_wdata),
        .tc_set (tc_set_i),
        .dreq   (dreq_i),
        .mask   (mask_o),
        .mode   (mode_o),
        .swreq  (sw_req_o),
        .cmd    (cmd_o),
        .status (status),
        .ptr_clr(ptr_clr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = word_sel && (wch == CHW'(c));

        chdma_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_addr  (io_wr && sel && !is_cnt),
            .wr_cnt   (io_wr && sel && is_cnt),
            .hi       (hi),
            .wdata    (io_wdata),
            .upd      (upd_en_i && (upd_ch_i == CHW'(c))),
            .upd_addr (upd_addr_i),
            .upd_cnt  (upd_cnt_i),
            .base_addr(base_addr_o[c*RW +: RW]),
            .base_cnt (base_cnt_o[c*RW +: RW]),
            .cur_addr (cur_a[c]),
            .cur_cnt  (cur_c[c])
        );

        assign cur_addr_o[c*RW +: RW] = cur_a[c];
        assign cur_cnt_o[c*RW +: RW]  = cur_c[c];
        assign autoinit_o[c] = mode_o[c*MODEW + AUTO_BIT];
    end

    // Read mux: current word byte by pointer, status at 0x8, zero elsewhere
    always_comb begin
        rd_word = is_cnt ? cur_c[wch] : cur_a[wch];
        if (word_sel)                    io_rdata = hi ? rd_word[RW-1:DW] : rd_word[DW-1:0];
        else if (io_addr == P_CMDSTAT)   io_rdata = status;
        else                             io_rdata = '0;
    end

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd)); // R2
    AST_RESET_MASKS: assert property (@(posedge clk)
        !rst_n |=> (mask_o == 4'hF) && (cmd_o == 8'h00)); // R11
endmodule

// File: tb/chdma_regfile_tb.sv
module chdma_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  tc_set_i = '0, dreq_i = '0;
    logic        upd_en_i = 1'b0;
    logic [1:0]  upd_ch_i = '0;
    logic [15:0] upd_addr_i = '0, upd_cnt_i = '0;
    logic [3:0]  mask_o, autoinit_o, sw_req_o;
    logic [23:0] mode_o;
    logic [7:0]  cmd_o;
    logic [63:0] base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    chdma_regfile u_dut (.*);

    // op(2) addr(4) data(8) expect(8); op 1 = write, 2 = read and compare
    localparam int NV = 19;
    localparam logic [21:0] VEC [NV] = '{
        {2'd1, 4'hC, 8'h00, 8'h00},  // pointer to low byte (R3)
        {2'd1, 4'h2, 8'h34, 8'h00},  // ch1 address low (R1)
        {2'd1, 4'h2, 8'h12, 8'h00},  // ch1 address high (R1)
        {2'd1, 4'h3, 8'hFF, 8'h00},  // ch1 count low
        {2'd1, 4'h3, 8'h00, 8'h00},  // ch1 count high
        {2'd2, 4'h2, 8'h00, 8'h34},  // read back low (R2)
        {2'd2, 4'h2, 8'h00, 8'h12},  // read back high (R2)
        {2'd2, 4'h3, 8'h00, 8'hFF},
        {2'd2, 4'h3, 8'h00, 8'h00},
        {2'd1, 4'h4, 8'hAA, 8'h00},  // ch2 address low, pointer now 1
        {2'd2, 4'h4, 8'h00, 8'h00},  // high byte read first (R2)
        {2'd2, 4'h4, 8'h00, 8'hAA},
        {2'd2, 4'h8, 8'h00, 8'h00},  // status idle (R7)
        {2'd1, 4'h9, 8'h06, 8'h00},  // set request ch2 (R9)
        {2'd2, 4'h8, 8'h00, 8'h40},
        {2'd1, 4'h9, 8'h02, 8'h00},  // clear request ch2 (R9)
        {2'd2, 4'h8, 8'h00, 8'h00},
        {2'd2, 4'hD, 8'h00, 8'h00},  // temporary register reads zero (R10)
        {2'd2, 4'hA, 8'h00, 8'h00}   // write-only port reads zero (R10)
    };

    task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input int rq);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 chk(rq, {56'd0, io_rdata}, {56'd0, exp});
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R0: watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk(11, {60'd0, mask_o}, 64'hF);
        chk(11, {56'd0, cmd_o}, 64'h0);
        chk(11, {40'd0, mode_o}, 64'h0);
        chk(11, base_addr_o, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21:20] == 2'd1) bus_wr(VEC[i][19:16], VEC[i][15:8]);
            else bus_rd(VEC[i][19:16], VEC[i][7:0], 2);
        end

        bus_wr(4'hC, 8'h00);
        chk(1, {48'd0, base_addr_o[31:16]}, 64'h1234);  // R1
        chk(1, {48'd0, base_cnt_o[31:16]}, 64'h00FF);

        // R6: mode stores bits [7:2]; bit 4 drives auto-initialize
        bus_wr(4'hB, 8'h59);
        chk(6, {58'd0, mode_o[11:6]}, 64'h16);
        chk(6, {60'd0, autoinit_o}, 64'h2);
        bus_wr(4'hB, 8'h46);
        chk(6, {58'd0, mode_o[17:12]}, 64'h11);
        bus_wr(4'hB, 8'hC3);
        chk(6, {58'd0, mode_o[23:18]}, 64'h30);
        chk(6, {60'd0, autoinit_o}, 64'h2);

        // R4 / R5: mask ports
        bus_wr(4'hA, 8'h01); chk(4, {60'd0, mask_o}, 64'hD);
        bus_wr(4'hA, 8'h05); chk(4, {60'd0, mask_o}, 64'hF);
        bus_wr(4'hE, 8'h00); chk(5, {60'd0, mask_o}, 64'h0);
        bus_wr(4'hF, 8'h3A); chk(5, {60'd0, mask_o}, 64'hA);
        bus_wr(4'hA, 8'h04); chk(4, {60'd0, mask_o}, 64'hB);

        // R12: engine update changes current copy only
        @(negedge clk);
        upd_en_i = 1'b1; upd_ch_i = 2'd1; upd_addr_i = 16'hBEEF; upd_cnt_i = 16'h0102;
        @(negedge clk);
        upd_en_i = 1'b0;
        chk(12, {48'd0, cur_addr_o[31:16]}, 64'hBEEF);
        chk(12, {48'd0, cur_cnt_o[31:16]}, 64'h0102);
        chk(12, {48'd0, base_addr_o[31:16]}, 64'h1234);
        bus_rd(4'h2, 8'hEF, 12);
        bus_rd(4'h2, 8'hBE, 12);

        // R12: host byte overrides engine update in the same cycle
        bus_wr(4'hC, 8'h00);
        @(negedge clk);
        io_addr = 4'h6; io_wdata = 8'h77; io_wr = 1'b1;
        upd_en_i = 1'b1; upd_ch_i = 2'd3; upd_addr_i = 16'h1111;
        @(negedge clk);
        io_wr = 1'b0; upd_en_i = 1'b0;
        chk(12, {48'd0, cur_addr_o[63:48]}, 64'h1177);
        chk(12, {48'd0, base_addr_o[63:48]}, 64'h0077);

        // R8: terminal-count flags and read-clear
        @(negedge clk); tc_set_i = 4'b0101;
        @(negedge clk); tc_set_i = 4'b0000;
        bus_rd(4'h8, 8'h05, 8);
        bus_rd(4'h8, 8'h00, 8);
        @(negedge clk);
        io_addr = 4'h8; io_rd = 1'b1; tc_set_i = 4'b1000;
        #1 chk(8, {56'd0, io_rdata}, 64'h00);
        @(negedge clk);
        io_rd = 1'b0; tc_set_i = 4'b0000;
        bus_rd(4'h8, 8'h08, 8);
        bus_rd(4'h8, 8'h00, 8);

        // R7: hardware request and command byte
        dreq_i = 4'b0001;
        bus_rd(4'h8, 8'h10, 7);
        dreq_i = 4'b0000;
        bus_wr(4'h8, 8'h5A);
        chk(7, {56'd0, cmd_o}, 64'h5A);

        // R10: master clear
        bus_wr(4'h9, 8'h05);
        @(negedge clk); tc_set_i = 4'b0010;
        @(negedge clk); tc_set_i = 4'b0000;
        bus_wr(4'hF, 8'h00);
        bus_wr(4'hC, 8'h00);
        bus_wr(4'h0, 8'h11);
        bus_wr(4'hD, 8'h00);
        chk(10, {60'd0, mask_o}, 64'hF);
        chk(10, {56'd0, cmd_o}, 64'h0);
        chk(10, {60'd0, sw_req_o}, 64'h0);
        chk(10, {58'd0, mode_o[11:6]}, 64'h16);
        bus_rd(4'h8, 8'h00, 10);
        bus_rd(4'h2, 8'hEF, 10);

        finish_run();
    end
endmodule